// File: doc/BRIEF.md
# Phase Comparator with Pump Steering and Lock Qualification

This block sits after the reference and programmable dividers of a frequency synthesizer. Each divider delivers a one-cycle pulse per period. The block compares the arrival times of the two pulses and turns the comparison into a three-state pump command: source, sink or high impedance. The analog pump and loop filter outside the block act on this command.

A lock qualifier measures how long the pump is active in each comparison period. After enough consecutive narrow periods it raises a lock flag for the status byte. The same condition drives a current-select bit that moves the pump from its acquisition current to its lower tracking current. A three-bit test code can force the pump into a fixed state. It can also replace the lock indication on the multiplexed test pin with the raw reference pulse or the raw divided-VCO pulse. A separate tuning-off bit turns off the tuning amplifier enable.

Top module: `phase_lock_ctrl`

## Requirements
- R1: A divided-VCO pulse that arrives before the reference pulse sets the lead flag. From the clock edge that samples that pulse, `pumpSource`=1 and `pumpSink`=0 until the reference pulse is sampled.
- R2: A reference pulse that arrives before the divided-VCO pulse sets the lag flag. From the clock edge that samples that pulse, `pumpSink`=1 and `pumpSource`=0 until the divided-VCO pulse is sampled.
- R3: When both flags are set, for example by simultaneous pulses, the output is high impedance (`pumpSource`=`pumpSink`=0). One cycle later both flags clear together. Pulses sampled on that clearing edge set the flags again. Source and sink are never both 1.
- R4: With `testMode` = 00x (bit 2 first) the pump follows the comparator. With 01x the pump is held high impedance. The comparator flags keep their state, and they drive the pump again once the code returns to 00x.
- R5: `testMode` = 110 forces sink (`pumpSink`=1, `pumpSource`=0). `testMode` = 111 forces source.
- R6: `testMode` = 100 holds the pump high impedance and puts the raw `refPulse` on `lockPin`. `testMode` = 101 does the same with the raw `vcoPulse`. Every other code puts `lockFlag` on `lockPin`.
- R7: Out of reset the pump is high impedance, `lockFlag`=1, `lockPin`=1, and `pumpCurrentLow`=0 (0 selects the 270 µA acquisition current, 1 selects the 70 µA tracking current).
- R8: In each period the active width is the number of cycles in which exactly one flag is set. It is judged on the edge where both flags are set. A width of at most `LOCK_WIN` is narrow. After `LOCK_COUNT` consecutive narrow periods, `lockFlag`=1 and `pumpCurrentLow`=1 from the judging edge of the last one.
- R9: A single period wider than `LOCK_WIN` clears `lockFlag`, `pumpCurrentLow` and the narrow-period count from its judging edge on.
- R10: `tuneEnable` is the inverse of `tuneOff`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vcoPulse | input | 1 | One-cycle pulse from the programmable (VCO) divider |
| refPulse | input | 1 | One-cycle pulse from the reference divider |
| testMode | input | 3 | Test code, bit 2 is the most significant |
| tuneOff | input | 1 | 1 turns the tuning amplifier off |
| pumpSource | output | 1 | Pump command: source current |
| pumpSink | output | 1 | Pump command: sink current |
| pumpCurrentLow | output | 1 | 1 selects tracking current, 0 acquisition current |
| lockFlag | output | 1 | Lock state for the status byte |
| lockPin | output | 1 | Multiplexed lock / test output |
| tuneEnable | output | 1 | Tuning amplifier enable |

## Verification
Two things can happen in one cycle: the comparator flags clear while a new pulse is sampled, and the lock qualifier judges the width of the period that just ended. Both are provoked by pulses placed on the clearing edge and by simultaneous pulses. The check is that the next period still produces the right pump command and that the judged width has the right effect on the lock flag. The test overrides are also applied while a comparator flag is pending, and the pending state is expected to reappear unchanged once normal mode returns.

// File: rtl/phase_lock_pkg.sv
`timescale 1ns/1ps
package phase_lock_pkg;

  // strobes from the test decoder to the comparator datapath
  typedef struct packed {
    logic forceZ;
    logic forceSink;
    logic forceSource;
    logic routeRef;
    logic routeVco;
  } pumpCtrl_t;

  localparam logic [2:0] CODE_SINK   = 3'b110;
  localparam logic [2:0] CODE_SOURCE = 3'b111;
  localparam logic [2:0] CODE_REF    = 3'b100;
  localparam logic [2:0] CODE_VCO    = 3'b101;

endpackage

// File: rtl/phase_lock_decode.sv
`timescale 1ns/1ps
module phase_lock_decode
  import phase_lock_pkg::*;
(
  input  logic [2:0] testMode,
  input  logic       tuneOff,
  output pumpCtrl_t  ctrlStb,
  output logic       tuneEnable
);

  always_comb begin
    ctrlStb = '0;
    casez (testMode)
      3'b00?:      ctrlStb = '0;
      3'b01?:      ctrlStb.forceZ = 1'b1;
      CODE_SINK:   ctrlStb.forceSink = 1'b1;
      CODE_SOURCE: ctrlStb.forceSource = 1'b1;
      CODE_REF: begin
        ctrlStb.forceZ   = 1'b1;
        ctrlStb.routeRef = 1'b1;
      end
      CODE_VCO: begin
        ctrlStb.forceZ   = 1'b1;
        ctrlStb.routeVco = 1'b1;
      end
      default:     ctrlStb = '0;
    endcase
  end

  assign tuneEnable = ~tuneOff;

endmodule

// File: rtl/phase_lock_datapath.sv
`timescale 1ns/1ps
module phase_lock_datapath
  import phase_lock_pkg::*;
#(
  parameter int LOCK_WIN   = 3,
  parameter int LOCK_COUNT = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      vcoPulse,
  input  logic      refPulse,
  input  pumpCtrl_t ctrlStb,
  output logic      pumpSource,
  output logic      pumpSink,
  output logic      pumpCurrentLow,
  output logic      lockFlag,
  output logic      lockPin
);

  localparam int WW = $clog2(LOCK_WIN + 2);
  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [WW-1:0] WIDTH_SAT  = WW'(LOCK_WIN + 1);
  localparam logic [WW-1:0] WIDTH_LIM  = WW'(LOCK_WIN);
  localparam logic [CW-1:0] GOOD_LAST  = CW'(LOCK_COUNT - 1);

  logic upQ, dnQ;
  logic bothSet;
  logic [WW-1:0] widthCnt;
  logic tooWide;
  logic [CW-1:0] goodCnt;
  logic lockQ, qualQ;
  logic pfdSource, pfdSink;

  assign bothSet = upQ & dnQ;

  // flag pair: both clear together one cycle after both are set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (bothSet) begin
      upQ <= vcoPulse;
      dnQ <= refPulse;
    end else begin
      upQ <= upQ | vcoPulse;
      dnQ <= dnQ | refPulse;
    end
  end

  // active width of the current period, saturating one past the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (bothSet) begin
      widthCnt <= '0;
    end else if ((upQ ^ dnQ) && (widthCnt != WIDTH_SAT)) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  assign tooWide = (widthCnt > WIDTH_LIM);

  // lock qualifier, judged once per period on the both-set edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
      lockQ   <= 1'b1;
      qualQ   <= 1'b0;
    end else if (bothSet) begin
      if (tooWide) begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
        qualQ   <= 1'b0;
      end else if (goodCnt >= GOOD_LAST) begin
        lockQ <= 1'b1;
        qualQ <= 1'b1;
      end else begin
        goodCnt <= goodCnt + 1'b1;
      end
    end
  end

  assign pfdSource = upQ & ~dnQ;
  assign pfdSink   = dnQ & ~upQ;

  always_comb begin
    if (ctrlStb.forceSource) begin
      pumpSource = 1'b1;
      pumpSink   = 1'b0;
    end else if (ctrlStb.forceSink) begin
      pumpSource = 1'b0;
      pumpSink   = 1'b1;
    end else if (ctrlStb.forceZ) begin
      pumpSource = 1'b0;
      pumpSink   = 1'b0;
    end else begin
      pumpSource = pfdSource;
      pumpSink   = pfdSink;
    end
  end

  always_comb begin
    if (ctrlStb.routeRef)      lockPin = refPulse;
    else if (ctrlStb.routeVco) lockPin = vcoPulse;
    else                       lockPin = lockQ;
  end

  assign lockFlag       = lockQ;
  assign pumpCurrentLow = qualQ;

  assert_flags_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    bothSet |=> (upQ == $past(vcoPulse)) && (dnQ == $past(refPulse)));

  assert_pump_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpSource && pumpSink));

  assert_wide_unlock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bothSet && tooWide) |=> (!lockQ && !qualQ && (goodCnt == '0)));

  assert_low_current_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    qualQ |-> lockQ);

  assert_lead_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!upQ && !dnQ && vcoPulse && !refPulse) |=> (upQ && !dnQ));

endmodule

// File: rtl/phase_lock_ctrl.sv
`timescale 1ns/1ps
module phase_lock_ctrl
  import phase_lock_pkg::*;
#(
  parameter int LOCK_WIN   = 3,
  parameter int LOCK_COUNT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vcoPulse,
  input  logic       refPulse,
  input  logic [2:0] testMode,
  input  logic       tuneOff,
  output logic       pumpSource,
  output logic       pumpSink,
  output logic       pumpCurrentLow,
  output logic       lockFlag,
  output logic       lockPin,
  output logic       tuneEnable
);

  pumpCtrl_t ctrlStb;

  phase_lock_decode decode_i (
    .testMode   (testMode),
    .tuneOff    (tuneOff),
    .ctrlStb    (ctrlStb),
    .tuneEnable (tuneEnable)
  );

  phase_lock_datapath #(
    .LOCK_WIN   (LOCK_WIN),
    .LOCK_COUNT (LOCK_COUNT)
  ) datapath_i (
    .clk            (clk),
    .rstN           (rstN),
    .vcoPulse       (vcoPulse),
    .refPulse       (refPulse),
    .ctrlStb        (ctrlStb),
    .pumpSource     (pumpSource),
    .pumpSink       (pumpSink),
    .pumpCurrentLow (pumpCurrentLow),
    .lockFlag       (lockFlag),
    .lockPin        (lockPin)
  );

  assert_forced_sink_R5: assert property (@(posedge clk) disable iff (!rstN)
    (testMode == 3'b110) |-> (pumpSink && !pumpSource));

  assert_forced_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    (testMode == 3'b111) |-> (pumpSource && !pumpSink));

  assert_hold_z_R4: assert property (@(posedge clk) disable iff (!rstN)
    (testMode[2:1] == 2'b01) |-> (!pumpSource && !pumpSink));

  assert_tune_R10: assert property (@(posedge clk) disable iff (!rstN)
    tuneEnable != tuneOff);

  assert_route_ref_R6: assert property (@(posedge clk) disable iff (!rstN)
    (testMode == 3'b100) |-> (lockPin == refPulse));

endmodule

// File: tb/phase_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_lock_ctrl_tb_top;

  localparam int LOCK_WIN   = 3;
  localparam int LOCK_COUNT = 4;
  localparam int NROWS      = 28;

  // row: [7:5] testMode, [4] vco, [3] ref, [2] expSource, [1] expSink, [0] expLockPin
  localparam logic [7:0] VEC [NROWS] = '{
    8'b000_10_10_1, 8'b000_00_10_1, 8'b000_01_00_1, 8'b000_00_00_1,
    8'b000_01_01_1, 8'b000_00_01_1, 8'b000_10_00_1, 8'b000_00_00_1,
    8'b000_11_00_1, 8'b000_00_00_1, 8'b010_10_00_1, 8'b011_00_00_1,
    8'b000_00_10_1, 8'b000_01_00_1, 8'b000_00_00_1, 8'b110_00_01_1,
    8'b111_00_10_1, 8'b100_01_00_1, 8'b100_00_00_0, 8'b101_10_00_1,
    8'b101_00_00_0, 8'b000_00_00_1, 8'b000_10_10_1, 8'b000_00_10_1,
    8'b000_00_10_1, 8'b000_00_10_1, 8'b000_01_00_1, 8'b000_00_00_0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vcoPulse = 1'b0;
  logic refPulse = 1'b0;
  logic [2:0] testMode = 3'b000;
  logic tuneOff = 1'b0;
  logic pumpSource, pumpSink, pumpCurrentLow, lockFlag, lockPin, tuneEnable;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  phase_lock_ctrl #(.LOCK_WIN(LOCK_WIN), .LOCK_COUNT(LOCK_COUNT)) dut_i (
    .clk(clk), .rstN(rstN), .vcoPulse(vcoPulse), .refPulse(refPulse),
    .testMode(testMode), .tuneOff(tuneOff), .pumpSource(pumpSource),
    .pumpSink(pumpSink), .pumpCurrentLow(pumpCurrentLow), .lockFlag(lockFlag),
    .lockPin(lockPin), .tuneEnable(tuneEnable)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic r);
    @(negedge clk);
    vcoPulse = v;
    refPulse = r;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    vcoPulse = 1'b0;
    refPulse = 1'b0;
    testMode = 3'b000;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // one comparison period whose active width is w cycles (w >= 1)
  task automatic runPeriod(input int w);
    step(1'b1, 1'b0);
    for (int i = 1; i < w; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7", "source", pumpSource, 1'b0);
    chk("R7", "sink", pumpSink, 1'b0);
    chk("R7", "lockFlag", lockFlag, 1'b1);
    chk("R7", "lockPin", lockPin, 1'b1);
    chk("R7", "currentLow", pumpCurrentLow, 1'b0);
    rstN = 1'b1;

    // R10
    tuneOff = 1'b0;
    #1 chk("R10", "tuneEnable off=0", tuneEnable, 1'b1);
    tuneOff = 1'b1;
    #1 chk("R10", "tuneEnable off=1", tuneEnable, 1'b0);
    tuneOff = 1'b0;

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      string tag;
      @(negedge clk);
      testMode = VEC[i][7:5];
      vcoPulse = VEC[i][4];
      refPulse = VEC[i][3];
      @(posedge clk);
      #1;
      if (VEC[i][7:6] == 2'b11)      tag = "R5";
      else if (VEC[i][7:6] == 2'b10) tag = "R6";
      else if (VEC[i][7:6] == 2'b01) tag = "R4";
      else if (VEC[i][2])            tag = "R1";
      else if (VEC[i][1])            tag = "R2";
      else if (i == NROWS - 1)       tag = "R9";
      else                           tag = "R3";
      chk(tag, $sformatf("row %0d source", i), pumpSource, VEC[i][2]);
      chk(tag, $sformatf("row %0d sink", i), pumpSink, VEC[i][1]);
      chk(tag, $sformatf("row %0d lockPin", i), lockPin, VEC[i][0]);
    end

    // R8: boundary width LOCK_WIN counts as narrow
    doReset();
    for (int p = 0; p < LOCK_COUNT - 1; p++) runPeriod(LOCK_WIN);
    chk("R8", "currentLow before last narrow", pumpCurrentLow, 1'b0);
    chk("R8", "lockFlag presumed", lockFlag, 1'b1);
    runPeriod(LOCK_WIN);
    chk("R8", "currentLow after narrow run", pumpCurrentLow, 1'b1);
    chk("R8", "lockFlag after narrow run", lockFlag, 1'b1);

    // R9: width LOCK_WIN+1 is wide
    runPeriod(LOCK_WIN + 1);
    chk("R9", "lockFlag after wide", lockFlag, 1'b0);
    chk("R9", "currentLow after wide", pumpCurrentLow, 1'b0);
    chk("R9", "lockPin after wide", lockPin, 1'b0);

    // R8: count restarts from zero
    for (int p = 0; p < LOCK_COUNT - 1; p++) runPeriod(1);
    chk("R8", "lockFlag before relock", lockFlag, 1'b0);
    runPeriod(1);
    chk("R8", "lockFlag relock", lockFlag, 1'b1);
    chk("R8", "currentLow relock", pumpCurrentLow, 1'b1);

    // R3: pulse on the clearing edge is captured
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R3", "recapture source", pumpSource, 1'b1);
    chk("R3", "recapture sink", pumpSink, 1'b0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule